// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block sits in the digital audio path ahead of the modulator. It fades a stereo sample stream down to silence when a mute is requested, and fades it back up when the request goes away. Every step of the fade is timed in audio frames, so the host can switch to a different signal source without a click and without stopping the stream. A mute is requested by an external pin or by a control bit. Either one is enough. The block holds an 8-bit gain level and moves it one step at a time toward its current target. The target is zero while a mute is requested and the programmed gain setting otherwise. Both channels are multiplied by this level.

If a mute is released while the fade-down is still running, the ramp turns around where it stands. It climbs back using as many steps as it had already taken. Each channel also has a long-silence detector. The detector raises a flag after a long run of exactly-zero samples and drops it on the first nonzero sample.

The level and the silence counters are cleared by the active-low reset, which also serves as the power-down input. A frame-enable input marks the one clock cycle per audio frame in which a new sample pair is present.

Top module: `softmute_ctrl`

## Requirements
- R1: A mute is requested while `mute_pin` is 1 or `mute_bit` is 1 (either one alone is enough). While a request is active the level never increases. With both inputs at 0 the target is `att_setting`.
- R2: While muting, the level falls from its current value by one step every 16 enabled frames and stops at 0. With a level of 255 the full fade takes 4080 enabled frames.
- R3: With no mute requested, the level rises by one step every 16 enabled frames until it equals `att_setting`. After reset the level is 0, so the block fades in from silence; a setting of 255 is reached after 4080 enabled frames.
- R4: A release that comes part way through a fade-down reverses the ramp from the level already reached. The step count restarts, so k steps down are undone in exactly 16·k enabled frames.
- R5: Cycles with `frame_en` low neither move the level nor count toward a step.
- R6: On each enabled frame, each output is registered as the input times the level (before that frame's step), divided by 256 and rounded toward zero. Both channels use the same level. The outputs hold between enabled frames.
- R7: `ramp_busy` is 1 exactly when the level differs from the current target (0 while muting, `att_setting` otherwise).
- R8: A channel's zero flag goes to 1 on the enabled frame that completes 8192 consecutive exactly-zero input samples on that channel, and not before.
- R9: A channel's zero flag goes to 0 on the enabled frame in which that channel's input is nonzero.
- R10: While `rst_n` is 0, the outputs, the level and both zero flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset / power-down |
| frame_en | input | 1 | One-cycle strobe per audio frame |
| mute_pin | input | 1 | Mute request from the external pin |
| mute_bit | input | 1 | Mute request from the control register |
| att_setting | input | 8 | Unmuted gain target (0..255, 256 = unity) |
| in_l | input | 24 | Left signed input sample |
| in_r | input | 24 | Right signed input sample |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| ramp_busy | output | 1 | Level differs from its target |
| zero_l | output | 1 | Left long-silence flag |
| zero_r | output | 1 | Right long-silence flag |

## Verification
The checker treats every cycle with `frame_en` high as one frame. Its properties relate only the level and the outputs from one frame to the next: they hold for any mute or setting sequence and for any spacing of enable strobes. The bench's frame arithmetic does assume a stable target, so the stimulus holds `att_setting` constant and changes the mute inputs only between frames. The silence-flag properties assume that samples are read only on enabled frames. The stimulus therefore mixes back-to-back strobes with strobes separated by idle cycles.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

    // Gain level width; the programmed setting shares it.
    localparam int unsigned LVL_W = 8;

    typedef logic [LVL_W-1:0] level_t;

    // Direction of the ramp relative to its target.
    typedef enum logic [1:0] {
        RAMP_IDLE = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/softmute_ramp.sv
module softmute_ramp
    import softmute_pkg::*;
#(
    parameter int unsigned STEP_FRAMES = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_en,
    input  logic   mute_req,
    input  level_t setting,
    output level_t level,
    output logic   busy
);

    localparam int unsigned PCW = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
    localparam logic [PCW-1:0] LAST_CNT = PCW'(STEP_FRAMES - 1);
    localparam logic [PCW-1:0] CNT_ONE  = PCW'(1);
    localparam level_t         LVL_ONE  = level_t'(1);

    typedef struct packed {
        level_t         level;
        level_t         target;
        logic [PCW-1:0] presc;
    } ramp_t;

    ramp_t          r_d, r_q;
    level_t         tgt;
    logic [PCW-1:0] cnt;
    ramp_dir_e      dir;

    always_comb begin
        tgt = mute_req ? '0 : setting;

        if (r_q.level < tgt) begin
            dir = RAMP_UP;
        end else if (r_q.level > tgt) begin
            dir = RAMP_DOWN;
        end else begin
            dir = RAMP_IDLE;
        end

        // A new target (mute edge, release, setting change) restarts the step count.
        cnt = (tgt != r_q.target) ? '0 : r_q.presc;

        r_d = r_q;
        if (frame_en) begin
            r_d.target = tgt;
            if (dir == RAMP_IDLE) begin
                r_d.presc = '0;
            end else if (cnt == LAST_CNT) begin
                r_d.presc = '0;
                r_d.level = (dir == RAMP_UP) ? (r_q.level + LVL_ONE) : (r_q.level - LVL_ONE);
            end else begin
                r_d.presc = cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level = r_q.level;
    assign busy  = (r_q.level != tgt);

endmodule

// File: rtl/softmute_scale.sv
module softmute_scale
    import softmute_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_en,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  level_t                     level,
    output logic signed [SAMPLE_W-1:0] scaled
);

    localparam int unsigned PW = SAMPLE_W + LVL_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] out;
    } scale_t;

    scale_t                     s_d, s_q;
    logic signed [PW-1:0]       prod;
    logic                       neg;
    logic                       frac;
    logic        [SAMPLE_W-1:0] quo;

    always_comb begin
        prod = $signed(sample) * $signed({1'b0, level});
        neg  = prod[PW-1];
        frac = |prod[LVL_W-1:0];
        // Arithmetic shift floors; a negative product with a remainder moves up by one.
        quo  = prod[PW-1:LVL_W];
        s_d  = s_q;
        if (frame_en) begin
            s_d.out = quo + {{(SAMPLE_W-1){1'b0}}, neg & frac};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign scaled = $signed(s_q.out);

endmodule

// File: rtl/softmute_zdet.sv
module softmute_zdet #(
    parameter int unsigned SAMPLE_W    = 24,
    parameter int unsigned ZERO_FRAMES = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zero_flag
);

    localparam int unsigned   CW      = $clog2(ZERO_FRAMES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(ZERO_FRAMES);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } zdet_t;

    zdet_t         z_d, z_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (z_q.cnt == CNT_MAX) ? z_q.cnt : (z_q.cnt + CNT_ONE);
        z_d     = z_q;
        if (frame_en) begin
            if (sample != '0) begin
                z_d.cnt  = '0;
                z_d.flag = 1'b0;
            end else begin
                z_d.cnt  = cnt_inc;
                z_d.flag = (cnt_inc == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_q <= '0;
        end else begin
            z_q <= z_d;
        end
    end

    assign zero_flag = z_q.flag;

endmodule

// File: rtl/softmute_ctrl.sv
module softmute_ctrl
    import softmute_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 24,
    parameter int unsigned STEP_FRAMES = 16,
    parameter int unsigned ZERO_FRAMES = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_en,
    input  logic                       mute_pin,
    input  logic                       mute_bit,
    input  logic [7:0]                 att_setting,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r,
    output logic                       ramp_busy,
    output logic                       zero_l,
    output logic                       zero_r
);

    localparam int unsigned NUM_CH = 2;

    logic                       mute_req;
    level_t                     level_q;
    logic signed [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_out [NUM_CH];
    logic                       ch_zero[NUM_CH];

    assign mute_req  = mute_pin | mute_bit;
    assign ch_in[0]  = in_l;
    assign ch_in[1]  = in_r;

    softmute_ramp #(
        .STEP_FRAMES(STEP_FRAMES)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_en(frame_en),
        .mute_req(mute_req),
        .setting (level_t'(att_setting)),
        .level   (level_q),
        .busy    (ramp_busy)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        softmute_scale #(
            .SAMPLE_W(SAMPLE_W)
        ) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .frame_en(frame_en),
            .sample  (ch_in[g]),
            .level   (level_q),
            .scaled  (ch_out[g])
        );

        softmute_zdet #(
            .SAMPLE_W   (SAMPLE_W),
            .ZERO_FRAMES(ZERO_FRAMES)
        ) u_zdet (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_en (frame_en),
            .sample   (ch_in[g]),
            .zero_flag(ch_zero[g])
        );
    end

    assign out_l  = ch_out[0];
    assign out_r  = ch_out[1];
    assign zero_l = ch_zero[0];
    assign zero_r = ch_zero[1];

endmodule

// File: rtl/softmute_ctrl_chk.sv
module softmute_ctrl_chk #(
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_en,
    input logic                       mute_pin,
    input logic                       mute_bit,
    input logic signed [SAMPLE_W-1:0] in_l,
    input logic signed [SAMPLE_W-1:0] in_r,
    input logic signed [SAMPLE_W-1:0] out_l,
    input logic signed [SAMPLE_W-1:0] out_r,
    input logic                       zero_l,
    input logic                       zero_r,
    input logic [7:0]                 level
);

    AST_NO_RISE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && (mute_pin || mute_bit)) |=> (level <= $past(level))); // R1

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_en |=> ((level == $past(level)) || (level == $past(level) + 8'd1)
                      || (level == $past(level) - 8'd1))); // R2

    AST_LEVEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> $stable(level)); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> ($stable(out_l) && $stable(out_r))); // R6

    AST_OUT_SIGN_L: assert property (@(posedge clk) disable iff (!rst_n)
        frame_en |=> ((out_l == '0) || (out_l[SAMPLE_W-1] == $past(in_l[SAMPLE_W-1])))); // R6

    AST_ZERO_RISE_L: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_l) |-> ($past(frame_en) && ($past(in_l) == '0))); // R8

    AST_ZERO_RISE_R: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_r) |-> ($past(frame_en) && ($past(in_r) == '0))); // R8

    AST_ZERO_DROP_L: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && (in_l != '0)) |=> !zero_l); // R9

    AST_ZERO_DROP_R: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && (in_r != '0)) |=> !zero_r); // R9

endmodule

bind softmute_ctrl softmute_ctrl_chk #(
    .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_en(frame_en),
    .mute_pin(mute_pin),
    .mute_bit(mute_bit),
    .in_l    (in_l),
    .in_r    (in_r),
    .out_l   (out_l),
    .out_r   (out_r),
    .zero_l  (zero_l),
    .zero_r  (zero_r),
    .level   (level_q)
);

// File: tb/softmute_ctrl_test.sv
module softmute_ctrl_test;

    localparam int SW = 24;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_en = 1'b0;
    logic                 mute_pin = 1'b0;
    logic                 mute_bit = 1'b0;
    logic [7:0]           att_setting = 8'd0;
    logic signed [SW-1:0] in_l = '0;
    logic signed [SW-1:0] in_r = '0;
    logic signed [SW-1:0] out_l, out_r;
    logic                 ramp_busy, zero_l, zero_r;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    softmute_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_en   (frame_en),
        .mute_pin   (mute_pin),
        .mute_bit   (mute_bit),
        .att_setting(att_setting),
        .in_l       (in_l),
        .in_r       (in_r),
        .out_l      (out_l),
        .out_r      (out_r),
        .ramp_busy  (ramp_busy),
        .zero_l     (zero_l),
        .zero_r     (zero_r)
    );

    typedef struct packed {
        logic [7:0]           setting;
        logic signed [SW-1:0] l;
        logic signed [SW-1:0] r;
        logic signed [SW-1:0] exp_l;
        logic signed [SW-1:0] exp_r;
    } vec_t;

    // Gain scaling vectors: level reaches the setting, then product/256 toward zero.
    localparam vec_t VECS [7] = '{
        '{8'd128, 24'sd1000,    -24'sd1000,   24'sd500,     -24'sd500},
        '{8'd255, 24'sd256,     -24'sd256,    24'sd255,     -24'sd255},
        '{8'd3,   24'sd100,     -24'sd100,    24'sd1,       -24'sd1},
        '{8'd1,   24'sd255,     -24'sd255,    24'sd0,       24'sd0},
        '{8'd200, 24'sd8388607, 24'sh800000,  24'sd6553599, -24'sd6553600},
        '{8'd64,  -24'sd3,      24'sd5,       24'sd0,       24'sd1},
        '{8'd0,   24'sd5000,    -24'sd5000,   24'sd0,       24'sd0}
    };

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Inputs change 5 ns after a rising edge; outputs are read at the same point.
    task automatic do_reset(input logic [7:0] setting);
        frame_en    = 1'b0;
        att_setting = setting;
        rst_n       = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
    endtask

    task automatic frames(input int n, input bit spaced);
        for (int i = 0; i < n; i++) begin
            frame_en = 1'b1;
            @(posedge clk);
            #5;
            frame_en = 1'b0;
            if (spaced) begin
                @(posedge clk);
                #5;
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        // R10: state held clear during reset
        in_l = 24'sd777;
        in_r = -24'sd777;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        check("R10 out_l in reset", out_l, 0);
        check("R10 zero_l in reset", zero_l, 0);
        check("R10 busy in reset", ramp_busy, 0);

        // Table walk: R6 scaling at the settled level, R3 fade-in length
        foreach (VECS[k]) begin
            in_l = VECS[k].l;
            in_r = VECS[k].r;
            do_reset(VECS[k].setting);
            frames(int'(VECS[k].setting) * 16 + 1, 1'b0);
            check("R6 out_l vector", out_l, VECS[k].exp_l);
            check("R6 out_r vector", out_r, VECS[k].exp_r);
            check("R7 busy settled", ramp_busy, 0);
        end

        // R3: fade-in from reset, level = floor(frames/16)
        in_l = 24'sd256;
        in_r = -24'sd256;
        do_reset(8'd255);
        check("R7 busy after reset", ramp_busy, 1);
        frames(800, 1'b0);
        check("R3 mid fade-in", out_l, 49);
        frames(3279, 1'b0);
        check("R7 busy one step short", ramp_busy, 1);
        frames(1, 1'b0);
        check("R3 reached at 4080", ramp_busy, 0);
        check("R6 output lags level", out_l, 254);
        frames(1, 1'b0);
        check("R3 out_l at setting", out_l, 255);
        check("R6 out_r at setting", out_r, -255);

        // R2 via pin: ten steps down in 160 frames
        mute_pin = 1'b1;
        frames(160, 1'b0);
        check("R2 after 160 muted frames", out_l, 246);
        frames(1, 1'b0);
        check("R2 after 161 muted frames", out_l, 245);
        check("R7 busy muting", ramp_busy, 1);

        // R4: release mid-ramp, ten steps back in 160 frames
        mute_pin = 1'b0;
        frames(159, 1'b0);
        check("R4 busy before return", ramp_busy, 1);
        frames(1, 1'b0);
        check("R4 back at setting", ramp_busy, 0);
        frames(1, 1'b0);
        check("R4 out_l restored", out_l, 255);

        // R1 / R2 via bit alone: full fade 4080 frames
        mute_bit = 1'b1;
        frames(4080, 1'b0);
        check("R2 one step left", out_l, 1);
        check("R1 bit mute reached 0", ramp_busy, 0);
        frames(1, 1'b0);
        check("R1 out_l silenced", out_l, 0);
        check("R1 out_r silenced", out_r, 0);

        // R5: idle cycles between strobes do not count
        mute_bit = 1'b0;
        frames(16, 1'b1);
        check("R5 spaced 16 frames", out_l, 0);
        repeat (40) @(posedge clk);
        #5;
        check("R5 no strobes no change", out_l, 0);
        frames(1, 1'b1);
        check("R5 spaced 17 frames", out_l, 1);

        // R8 / R9 / R10 on the silence detectors
        in_l = '0;
        in_r = 24'sd7;
        do_reset(8'd0);
        frames(8191, 1'b0);
        check("R8 zero_l at 8191", zero_l, 0);
        frames(1, 1'b0);
        check("R8 zero_l at 8192", zero_l, 1);
        check("R8 zero_r with signal", zero_r, 0);
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check("R10 zero_l cleared by reset", zero_l, 0);
        rst_n = 1'b1;
        frames(4096, 1'b1);
        frames(4096, 1'b0);
        check("R8 zero_l after spaced run", zero_l, 1);
        in_l = -24'sd1;
        frames(1, 1'b0);
        check("R9 zero_l drops", zero_l, 0);
        in_l = '0;
        frames(5, 1'b0);
        check("R9 count restarted", zero_l, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule